// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits at the end of a data converter's sample path. On every sample clock it either forwards the live converter word or replaces it with a known 14-bit test word. A receiver can then check its capture and timing against a predictable stream. A 4-bit mode value, held in a control register elsewhere, selects the pattern. The patterns are:

- fixed levels;
- two-word alternations: checkerboard, all-ones/all-zeros, and two user words;
- pseudorandom words taken from an external PN generator;
- a counting ramp.

An optional output stage turns two's complement words into offset binary. Only the live data, the fixed levels, the pseudorandom words and the user words go through this stage. The checkerboard, the ones/zeros toggle and the ramp leave the block unchanged whatever the format setting.

The output is registered. The word on `data_out` after a clock edge reflects the mode, format setting and input words sampled at that edge. When the mode changes, the new pattern starts at that edge. Any two-word pattern then begins again with its first word, and the ramp begins again from zero.

Top module: `tpg_top`

## Requirements
- R1: While `rst_n` is low and after reset is released, `data_out` is 0x0000 until the first active edge. The first two-word pattern after reset starts with its first word.
- R2: With mode 0000 (live), `data_out` after an edge equals `sample_in` sampled at that edge, subject to the format stage.
- R3: Modes 0001, 0010 and 0011 give 0x0000, 0x1FFF and 0x2000 on every sample when `fmt_offset` = 0.
- R4: Mode 0100 alternates 0x2AAA (first word) and 0x1555 on successive samples, regardless of `fmt_offset`.
- R5: Mode 0111 alternates 0x3FFF (first word) and 0x0000 on successive samples, regardless of `fmt_offset`.
- R6: Mode 1000 alternates `user_word_a` (first word) and `user_word_b`, each sampled at its own edge and subject to the format stage.
- R7: Mode 0101 outputs `pn_long_word` and mode 0110 outputs `pn_short_word`, sampled at the edge and subject to the format stage.
- R8: Mode 1111 outputs 0x0000 on the first sample after entering the mode. Each following sample adds one, and the count wraps from 0x3FFF to 0x0000. It is not affected by `fmt_offset`.
- R9: When `fmt_offset` = 1, the format stage inverts bit 13 of the word for modes 0000, 0001, 0010, 0011, 0101, 0110, 1000 and 1001–1110. It leaves the word unchanged for modes 0100, 0111 and 1111.
- R10: A change of `mode` takes effect at the next edge and restarts any two-word alternation at its first word.
- R11: The unused codes 1001 through 1110 behave as mode 0000 (live data through the format stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | 14 | Live converter word, two's complement |
| mode | input | 4 | Pattern select code |
| fmt_offset | input | 1 | 1 selects offset binary output for formatted modes |
| user_word_a | input | 14 | First user pattern word |
| user_word_b | input | 14 | Second user pattern word |
| pn_long_word | input | 14 | Current word of the long PN sequence |
| pn_short_word | input | 14 | Current word of the short PN sequence |
| data_out | output | 14 | Registered output word |

## Verification
The bench builds the block with its default width of 14 bits. At that width, every fixed level, checkerboard word and format flip can be compared against literal values taken from the requirements. With this width, the full ramp cycle is 16384 samples, so the bench can observe the wrap from 0x3FFF back to zero within one run. The vector table walks mode changes in and out of each two-word pattern at both phases, to reach the restart behaviour. A reset in the middle of a pattern covers the return to the first word.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [3:0] {
    M_LIVE    = 4'b0000,
    M_MID     = 4'b0001,
    M_FS_POS  = 4'b0010,
    M_FS_NEG  = 4'b0011,
    M_CHECKER = 4'b0100,
    M_PN_LONG = 4'b0101,
    M_PN_SHRT = 4'b0110,
    M_TOGGLE  = 4'b0111,
    M_USER    = 4'b1000,
    M_RAMP    = 4'b1111
  } mode_e;

  // Modes whose word is sent through the offset-binary stage.
  function automatic logic takes_format(input logic [3:0] m);
    case (m)
      M_CHECKER, M_TOGGLE, M_RAMP: takes_format = 1'b0;
      default:                     takes_format = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/tpg_sequencer.sv
module tpg_sequencer #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  output logic          mode_chg,
  output logic          use_word2,
  output logic [DW-1:0] ramp_val
);
  import tpg_pkg::*;

  logic [3:0]    mode_q;
  logic          sel2_q;
  logic [DW-1:0] ramp_q;

  assign mode_chg  = (mode != mode_q);
  assign use_word2 = sel2_q & ~mode_chg;
  assign ramp_val  = mode_chg ? '0 : ramp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_LIVE;
      sel2_q <= 1'b0;
      ramp_q <= '0;
    end else begin
      mode_q <= mode;
      sel2_q <= ~use_word2;
      if (mode == M_RAMP) ramp_q <= ramp_val + 1'b1;
    end
  end

endmodule

// File: rtl/tpg_word_mux.sv
module tpg_word_mux #(
  parameter int DW = 14
) (
  input  logic [3:0]    mode,
  input  logic          use_word2,
  input  logic [DW-1:0] ramp_val,
  input  logic [DW-1:0] sample_in,
  input  logic [DW-1:0] user_word_a,
  input  logic [DW-1:0] user_word_b,
  input  logic [DW-1:0] pn_long_word,
  input  logic [DW-1:0] pn_short_word,
  output logic [DW-1:0] raw_word,
  output logic          fmt_en
);
  import tpg_pkg::*;

  localparam logic [DW-1:0] W_MID    = '0;
  localparam logic [DW-1:0] W_FS_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] W_FS_NEG = {1'b1, {(DW-1){1'b0}}};

  // Alternating bits with the given value at the MSB.
  function automatic logic [DW-1:0] checker_word(input logic msb_val);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = ((DW - 1 - i) % 2 == 0) ? msb_val : ~msb_val;
    return w;
  endfunction

  always_comb begin
    fmt_en = takes_format(mode);
    case (mode)
      M_MID:     raw_word = W_MID;
      M_FS_POS:  raw_word = W_FS_POS;
      M_FS_NEG:  raw_word = W_FS_NEG;
      M_CHECKER: raw_word = checker_word(~use_word2);
      M_PN_LONG: raw_word = pn_long_word;
      M_PN_SHRT: raw_word = pn_short_word;
      M_TOGGLE:  raw_word = use_word2 ? '0 : '1;
      M_USER:    raw_word = use_word2 ? user_word_b : user_word_a;
      M_RAMP:    raw_word = ramp_val;
      default:   raw_word = sample_in;
    endcase
  end

endmodule

// File: rtl/tpg_formatter.sv
module tpg_formatter #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] raw_word,
  input  logic          fmt_en,
  input  logic          fmt_offset,
  output logic [DW-1:0] data_out
);

  function automatic logic [DW-1:0] to_offset_bin(input logic [DW-1:0] w);
    return {~w[DW-1], w[DW-2:0]};
  endfunction

  logic          flip;
  logic [DW-1:0] word_next;

  assign flip      = fmt_en & fmt_offset;
  assign word_next = flip ? to_offset_bin(raw_word) : raw_word;

  always_ff @(posedge clk) begin
    if (!rst_n) data_out <= '0;
    else        data_out <= word_next;
  end

  // R9: only the MSB may differ between raw and formatted word
  p_fmt_msb_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_next[DW-2:0] == raw_word[DW-2:0]);

endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sample_in,
  input  logic [3:0]    mode,
  input  logic          fmt_offset,
  input  logic [DW-1:0] user_word_a,
  input  logic [DW-1:0] user_word_b,
  input  logic [DW-1:0] pn_long_word,
  input  logic [DW-1:0] pn_short_word,
  output logic [DW-1:0] data_out
);
  import tpg_pkg::*;

  localparam logic [DW-1:0] CHK_A = {(DW/2 + 1){2'b10}} >> (2 - DW % 2 + ((DW / 2 + 1) * 2 - DW - (2 - DW % 2)));
  localparam logic [DW-1:0] FS_P  = {1'b0, {(DW-1){1'b1}}};

  logic          mode_chg;
  logic          use_word2;
  logic [DW-1:0] ramp_val;
  logic [DW-1:0] raw_word;
  logic          fmt_en;

  tpg_sequencer #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .use_word2 (use_word2),
    .ramp_val  (ramp_val)
  );

  tpg_word_mux #(.DW(DW)) u_mux (
    .mode          (mode),
    .use_word2     (use_word2),
    .ramp_val      (ramp_val),
    .sample_in     (sample_in),
    .user_word_a   (user_word_a),
    .user_word_b   (user_word_b),
    .pn_long_word  (pn_long_word),
    .pn_short_word (pn_short_word),
    .raw_word      (raw_word),
    .fmt_en        (fmt_en)
  );

  tpg_formatter #(.DW(DW)) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_word   (raw_word),
    .fmt_en     (fmt_en),
    .fmt_offset (fmt_offset),
    .data_out   (data_out)
  );

  // R2: live data passes unchanged with two's complement output
  p_live_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LIVE && !fmt_offset) |=> data_out == $past(sample_in));

  // R3: positive full scale level
  p_fs_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FS_POS && !fmt_offset) |=> data_out == FS_P);

  // R4: checkerboard output is always one of its two words
  p_checker_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CHECKER) |=> (data_out == CHK_A || data_out == ~CHK_A));

  // R8: ramp steps by one while the mode is held
  p_ramp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RAMP && !mode_chg) |=> data_out == DW'($past(data_out) + 1'b1));

  // R10: entering the toggle pattern starts on the all-ones word
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && mode == M_TOGGLE) |=> data_out == '1);

endmodule

// File: tb/tb_tpg_top.sv
`timescale 1ns/1ps
module tb_tpg_top;

  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] sample_in, user_word_a, user_word_b, pn_long_word, pn_short_word;
  logic [3:0]    mode;
  logic          fmt_offset;
  logic [DW-1:0] data_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  tpg_top #(.DW(DW)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_in     (sample_in),
    .mode          (mode),
    .fmt_offset    (fmt_offset),
    .user_word_a   (user_word_a),
    .user_word_b   (user_word_b),
    .pn_long_word  (pn_long_word),
    .pn_short_word (pn_short_word),
    .data_out      (data_out)
  );

  typedef struct packed {
    logic [3:0]    md;
    logic          fmt;
    logic [DW-1:0] smp;
    logic [DW-1:0] ua;
    logic [DW-1:0] ub;
    logic [DW-1:0] pnl;
    logic [DW-1:0] pns;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h1234}, // R2
    '{4'h0, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h3234}, // R9
    '{4'h1, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h0000}, // R3
    '{4'h1, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h2000}, // R9
    '{4'h2, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h1FFF}, // R3
    '{4'h3, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h2000}, // R3
    '{4'h3, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h0000}, // R9
    '{4'h4, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h2AAA}, // R4
    '{4'h4, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h1555}, // R4 R9
    '{4'h4, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h2AAA}, // R4
    '{4'h7, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h3FFF}, // R5
    '{4'h7, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h0000}, // R5
    '{4'h8, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h0ABC}, // R6
    '{4'h8, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h3001}, // R6
    '{4'h8, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h2ABC}, // R6 R9
    '{4'h5, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h3AFF, 14'h0092, 14'h3AFF}, // R7
    '{4'h5, 1'b1, 14'h1234, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h325B}, // R7 R9
    '{4'h6, 1'b0, 14'h1234, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h0092}, // R7
    '{4'hA, 1'b0, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h0777}, // R11
    '{4'hE, 1'b1, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h2777}, // R11
    '{4'h4, 1'b0, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h2AAA}, // R10
    '{4'h7, 1'b0, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h3FFF}, // R10
    '{4'h4, 1'b0, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h2AAA}, // R10
    '{4'hF, 1'b1, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h0000}, // R8
    '{4'hF, 1'b1, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h0001}, // R8
    '{4'hF, 1'b0, 14'h0777, 14'h0ABC, 14'h3001, 14'h125B, 14'h0092, 14'h0002}  // R8
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: data_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    mode          = v.md;
    fmt_offset    = v.fmt;
    sample_in     = v.smp;
    user_word_a   = v.ua;
    user_word_b   = v.ub;
    pn_long_word  = v.pnl;
    pn_short_word = v.pns;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: data_out=%h expected=run to finish", data_out);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int ramp_errs;
    rst_n = 1'b0;
    mode = 4'h0; fmt_offset = 1'b0; sample_in = 14'h1234;
    user_word_a = '0; user_word_b = '0; pn_long_word = '0; pn_short_word = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", data_out, 14'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1 before first edge", data_out, 14'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("vector %0d (R2..R11 table)", i), data_out, VECS[i].exp);
    end

    // R8: full ramp cycle with wrap, format select toggling must not matter
    begin
      vec_t v;
      v = VECS[0];
      v.md = 4'h7;
      apply(v);
      ramp_errs = 0;
      v.md = 4'hF;
      for (int n = 0; n <= (1 << DW); n++) begin
        v.fmt = n[3];
        apply(v);
        if (data_out !== DW'(n)) ramp_errs++;
        if (n == (1 << DW) - 1) check("R8 ramp top", data_out, 14'h3FFF);
        if (n == (1 << DW))     check("R8 ramp wrap", data_out, 14'h0000);
      end
      check("R8 ramp sequence errors", DW'(ramp_errs), 14'h0000);
    end

    // R1: reset in the middle of the checkerboard, word 2 phase pending
    begin
      vec_t v;
      v = VECS[7];
      apply(v);
      check("R4 checker first word", data_out, 14'h2AAA);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R1 reset mid pattern", data_out, 14'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 restart after reset", data_out, 14'h2AAA);
      @(posedge clk);
      #1;
      check("R4 second word after reset", data_out, 14'h1555);
    end

    // R6: user words sampled live at each edge
    begin
      vec_t v;
      v = VECS[12];
      v.ua = 14'h0011; v.ub = 14'h0022;
      apply(v);
      check("R6 user word a", data_out, 14'h0011);
      v.ub = 14'h1357;
      apply(v);
      check("R6 user word b live", data_out, 14'h1357);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule